// File: doc/BRIEF.md
# Protected Watchdog Register Front End

This block is the register side of a two-stage watchdog. It sits between a simple register write/read port and a separate countdown core. It holds the two stage preload values, the configuration fields and the lock and enable bits. It drives them to the core as plain levels, and it turns keep-alive and flag-clear writes into single-cycle pulses. The countdown, the timeout actions and the bus bridge that feeds the port are outside this block.

The memory window holds the two preloads and a kick register. These are protected. A write to one of them takes effect only when it directly follows a two-write key sequence on the kick offset. Each key sequence grants exactly one protected write. A second register pair, selected by `creg_sel`, holds the configuration fields and the lock byte. Once software sets the lock bit, the enable, free-run and lock settings stay fixed until reset. The core reports an earlier watchdog timeout on `prev_tmo`, and software reads that flag back from the kick offset.

Top module: `wdog_regfront`

## Requirements
- R1: After reset both preloads are 0xFFFFF, the block is unlocked, disabled and not free-running, reboot is enabled, the interrupt type is 0 (IRQ), the slow clock is selected, and the key sequence is at its idle step.
- R2: Writing exactly 0x80 to offset 0xC moves the key sequence to step 1 from any step. Writing exactly 0x86 to offset 0xC while at step 1 arms it. Protected writes made without the full sequence have no effect.
- R3: While armed, the next write that is not 0x80 to offset 0xC is the one protected write, and the sequence then returns to idle. A write to an undecoded offset (anything other than 0x0, 0x4 or 0xC) is dropped, but it still uses up the grant.
- R4: A protected write to offset 0x0 loads the stage-1 preload, and one to offset 0x4 loads the stage-2 preload. Only the low 20 bits of the write data are kept.
- R5: When `creg_sel`=1, the lock byte is selected. Bit 0 is lock, bit 1 is enable and bit 2 is free-run. A read returns these values in the same bit positions.
- R6: While lock is set, writes to the lock byte are ignored. Only reset clears lock.
- R7: When `creg_sel`=0, the configuration byte is selected. Setting bit 5 disables reboot. Bit 2 selects the fast clock. Bits 1:0 give the interrupt type (0 IRQ, 2 SMI, 3 none). A read returns the fields in the same bit positions.
- R8: A protected write to 0xC with bit 8 set raises `wd_reload` for exactly one cycle, the cycle after the write edge.
- R9: A protected write to 0xC with bit 9 or bit 12 set raises `wd_flag_clr` for exactly one cycle, the cycle after the write edge.
- R10: `mem_rdata` returns 0x1200 at offset 0xC while `prev_tmo` is high, and 0 at 0xC otherwise. It returns 0 at every other offset, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_we | input | 1 | Window write strobe, one cycle per write |
| mem_addr | input | 4 | Window byte offset, for both writes and reads |
| mem_wdata | input | DATA_W | Window write data |
| mem_rdata | output | DATA_W | Window read data, combinational from `mem_addr` |
| creg_we | input | 1 | Configuration/lock byte write strobe |
| creg_sel | input | 1 | 0 selects the configuration byte, 1 selects the lock byte |
| creg_wdata | input | CREG_W | Configuration/lock write data |
| creg_rdata | output | CREG_W | Read-back of the selected byte |
| prev_tmo | input | 1 | Earlier-timeout flag from the countdown core |
| wd_enable | output | 1 | Countdown enable |
| wd_free_run | output | 1 | Restart stage 1 after stage 2 expires |
| wd_fast_clk | output | 1 | Fast clock scale select |
| wd_int_type | output | 2 | Stage-1 interrupt type |
| wd_reboot_en | output | 1 | Reboot action enabled |
| wd_preload1 | output | PRE_W | Stage-1 preload |
| wd_preload2 | output | PRE_W | Stage-2 preload |
| wd_reload | output | 1 | Keep-alive pulse |
| wd_flag_clr | output | 1 | Earlier-timeout flag clear pulse |

## Verification
Every stored value changes on the clock edge that samples its write strobe. So the preloads, the configuration and lock fields, and the key-sequence step are all visible from the half cycle after that edge. The `wd_reload` and `wd_flag_clr` pulses are high in exactly that one cycle and low in the next. The bench drives each write on a falling edge and releases it on the following falling edge. It checks levels and pulse highs right at that second falling edge, and checks that each pulse is low one cycle later. Read data is combinational, so the bench checks it shortly after changing `mem_addr` or `prev_tmo`, with no clock edge in between.

// File: rtl/wdrf_pkg.sv
// Shared constants and types for the protected watchdog register front end.
// Assumes a 16-byte window addressed by a 4-bit byte offset.
package wdrf_pkg;

    localparam int WIN_AW = 4;

    // Offsets within the window that carry behaviour.
    localparam logic [WIN_AW-1:0] OFS_PRE_STEP = 4'h4;
    localparam logic [WIN_AW-1:0] OFS_KICK     = 4'hC;

    // Key values for the unlock sequence.
    localparam int KEY_OPEN = 'h80;
    localparam int KEY_ARM  = 'h86;

    // Kick register bit positions.
    localparam int KICK_RELOAD_BIT = 8;
    localparam int KICK_CLR_BIT_A  = 9;
    localparam int KICK_CLR_BIT_B  = 12;
    localparam int FLAG_READ_VAL   = 'h1200;

    // Configuration byte bit positions.
    localparam int CFG_NOBOOT_BIT = 5;
    localparam int CFG_FAST_BIT   = 2;

    // Lock byte bit positions.
    localparam int LCK_LOCK_BIT = 0;
    localparam int LCK_EN_BIT   = 1;
    localparam int LCK_FREE_BIT = 2;

    typedef enum logic [1:0] {
        ULK_IDLE  = 2'd0,
        ULK_STEP1 = 2'd1,
        ULK_ARMED = 2'd2
    } ulk_state_t;

endpackage

// File: rtl/wdrf_unlock.sv
// Key-sequence tracker. It grants one protected window write after the
// two key writes. Assumes each write strobe lasts one cycle.
module wdrf_unlock
    import wdrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WIN_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ulk_state_t        state,
    output logic              grant
);

    logic key_open;
    logic key_arm;

    // Decode the key writes and the single protected grant.
    always_comb begin
        key_open = we && (addr == OFS_KICK) && (wdata == DATA_W'(KEY_OPEN));
        key_arm  = we && (addr == OFS_KICK) && (wdata == DATA_W'(KEY_ARM))
                   && (state == ULK_STEP1);
        grant    = we && (state == ULK_ARMED) && !key_open;
    end

    // Step the sequence; a granted write returns it to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= ULK_IDLE;
        else if (key_open) state <= ULK_STEP1;
        else if (key_arm)  state <= ULK_ARMED;
        else if (grant)    state <= ULK_IDLE;
    end

endmodule

// File: rtl/wdrf_mmio.sv
// Protected window registers: stage preloads, kick pulses and read-back.
// Assumes grant is high only for the one write allowed after a key sequence.
module wdrf_mmio
    import wdrf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PRE_W   = 20,
    parameter int NUM_STG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grant,
    input  logic [WIN_AW-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     prev_tmo,
    output logic [NUM_STG*PRE_W-1:0] preload_flat,
    output logic                     reload,
    output logic                     flag_clr,
    output logic [DATA_W-1:0]        rdata
);

    logic kick_hit;
    logic unused_bits;

    assign kick_hit    = grant && (addr == OFS_KICK);
    assign unused_bits = ^wdata;

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        localparam logic [WIN_AW-1:0] STG_OFS = WIN_AW'(g * OFS_PRE_STEP);
        // Hold one stage preload; a protected write keeps the low bits only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                preload_flat[g*PRE_W +: PRE_W] <= '1;
            else if (grant && (addr == STG_OFS))
                preload_flat[g*PRE_W +: PRE_W] <= wdata[PRE_W-1:0];
        end
    end

    // Turn a granted kick write into one-cycle reload and flag-clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload   <= 1'b0;
            flag_clr <= 1'b0;
        end else begin
            reload   <= kick_hit && wdata[KICK_RELOAD_BIT];
            flag_clr <= kick_hit && (wdata[KICK_CLR_BIT_A] || wdata[KICK_CLR_BIT_B]);
        end
    end

    // Read-back: only the kick offset reports the earlier-timeout flag.
    always_comb begin
        rdata = '0;
        if ((addr == OFS_KICK) && prev_tmo) rdata = DATA_W'(FLAG_READ_VAL);
    end

endmodule

// File: rtl/wdrf_ctl.sv
// Configuration and lock bytes. Once lock is set, the lock byte is frozen
// until reset. Assumes creg_sel is stable while creg_we is high.
module wdrf_ctl
    import wdrf_pkg::*;
#(
    parameter int CREG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [CREG_W-1:0] wdata,
    output logic              lock_q,
    output logic              enable,
    output logic              free_run,
    output logic              reboot_en,
    output logic              fast_clk,
    output logic [1:0]        int_type,
    output logic [CREG_W-1:0] rdata
);

    logic unused_bits;
    assign unused_bits = ^wdata;

    // Configuration byte: reboot, clock scale and interrupt type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reboot_en <= 1'b1;
            fast_clk  <= 1'b0;
            int_type  <= 2'd0;
        end else if (we && !sel) begin
            reboot_en <= !wdata[CFG_NOBOOT_BIT];
            fast_clk  <= wdata[CFG_FAST_BIT];
            int_type  <= wdata[1:0];
        end
    end

    // Lock byte: writable only while lock is clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            enable   <= 1'b0;
            free_run <= 1'b0;
        end else if (we && sel && !lock_q) begin
            lock_q   <= wdata[LCK_LOCK_BIT];
            enable   <= wdata[LCK_EN_BIT];
            free_run <= wdata[LCK_FREE_BIT];
        end
    end

    // Read back the selected byte with the fields in their write positions.
    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[LCK_LOCK_BIT] = lock_q;
            rdata[LCK_EN_BIT]   = enable;
            rdata[LCK_FREE_BIT] = free_run;
        end else begin
            rdata[CFG_NOBOOT_BIT] = !reboot_en;
            rdata[CFG_FAST_BIT]   = fast_clk;
            rdata[1:0]            = int_type;
        end
    end

endmodule

// File: rtl/wdog_regfront.sv
// Top of the protected watchdog register front end. It ties the key-sequence
// tracker, the window registers and the configuration/lock bytes to the
// countdown-core control outputs. Assumes single-cycle write strobes.
module wdog_regfront
    import wdrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 20,
    parameter int CREG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic [3:0]        mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    input  logic              creg_we,
    input  logic              creg_sel,
    input  logic [CREG_W-1:0] creg_wdata,
    output logic [CREG_W-1:0] creg_rdata,
    input  logic              prev_tmo,
    output logic              wd_enable,
    output logic              wd_free_run,
    output logic              wd_fast_clk,
    output logic [1:0]        wd_int_type,
    output logic              wd_reboot_en,
    output logic [PRE_W-1:0]  wd_preload1,
    output logic [PRE_W-1:0]  wd_preload2,
    output logic              wd_reload,
    output logic              wd_flag_clr
);

    localparam int NUM_STG = 2;

    ulk_state_t               ulk_st;
    logic                     grant;
    logic                     lock_q;
    logic [NUM_STG*PRE_W-1:0] preload_flat;

    wdrf_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .state (ulk_st),
        .grant (grant)
    );

    wdrf_mmio #(.DATA_W(DATA_W), .PRE_W(PRE_W), .NUM_STG(NUM_STG)) u_mmio (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .addr         (mem_addr),
        .wdata        (mem_wdata),
        .prev_tmo     (prev_tmo),
        .preload_flat (preload_flat),
        .reload       (wd_reload),
        .flag_clr     (wd_flag_clr),
        .rdata        (mem_rdata)
    );

    wdrf_ctl #(.CREG_W(CREG_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (creg_we),
        .sel       (creg_sel),
        .wdata     (creg_wdata),
        .lock_q    (lock_q),
        .enable    (wd_enable),
        .free_run  (wd_free_run),
        .reboot_en (wd_reboot_en),
        .fast_clk  (wd_fast_clk),
        .int_type  (wd_int_type),
        .rdata     (creg_rdata)
    );

    assign wd_preload1 = preload_flat[0 +: PRE_W];
    assign wd_preload2 = preload_flat[PRE_W +: PRE_W];

endmodule

// File: rtl/wdrf_chk.sv
// Checker for wdog_regfront, attached by bind. It relates the key sequence,
// the stored values and the output pulses over time.
module wdrf_chk
    import wdrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [3:0]        mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input ulk_state_t        ulk_st,
    input logic              lock_q,
    input logic              wd_enable,
    input logic              wd_free_run,
    input logic [PRE_W-1:0]  wd_preload1,
    input logic              wd_reload,
    input logic              wd_flag_clr
);

    // R2: the opening key moves the sequence to step 1.
    p_key_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == OFS_KICK && mem_wdata == DATA_W'(KEY_OPEN))
        |=> (ulk_st == ULK_STEP1));

    // R3: an armed sequence returns to idle after its one protected write.
    p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ulk_st == ULK_ARMED &&
         !(mem_addr == OFS_KICK && mem_wdata == DATA_W'(KEY_OPEN)))
        |=> (ulk_st == ULK_IDLE));

    // R4: the stage-1 preload changes only after an armed write to offset 0.
    p_preload_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wd_preload1)
        |-> $past(ulk_st == ULK_ARMED && mem_we && mem_addr == 4'h0));

    // R6: once set, lock freezes the lock byte fields.
    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(lock_q) && $stable(wd_enable) && $stable(wd_free_run)));

    // R8: a reload pulse follows an armed kick write with the reload bit.
    p_reload_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reload |-> $past(ulk_st == ULK_ARMED && mem_we &&
                            mem_addr == OFS_KICK && mem_wdata[KICK_RELOAD_BIT]));

    // R8: a reload pulse lasts one cycle.
    p_reload_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reload |=> !wd_reload);

    // R9: a flag-clear pulse follows an armed kick write with a clear bit.
    p_clr_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag_clr |-> $past(ulk_st == ULK_ARMED && mem_we && mem_addr == OFS_KICK &&
                              (mem_wdata[KICK_CLR_BIT_A] || mem_wdata[KICK_CLR_BIT_B])));

    // R10: offsets other than the kick offset always read zero.
    p_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != OFS_KICK) |-> (mem_rdata == '0));

endmodule

bind wdog_regfront wdrf_chk #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .ulk_st      (ulk_st),
    .lock_q      (lock_q),
    .wd_enable   (wd_enable),
    .wd_free_run (wd_free_run),
    .wd_preload1 (wd_preload1),
    .wd_reload   (wd_reload),
    .wd_flag_clr (wd_flag_clr)
);

// File: tb/tb_wdog_regfront.sv
// Directed bench for wdog_regfront: one task per scenario, each checking its
// own results at falling edges.
module tb_wdog_regfront;

    localparam int DATA_W = 32;
    localparam int PRE_W  = 20;
    localparam int CREG_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mem_we = 1'b0;
    logic [3:0]        mem_addr = '0;
    logic [DATA_W-1:0] mem_wdata = '0;
    logic [DATA_W-1:0] mem_rdata;
    logic              creg_we = 1'b0;
    logic              creg_sel = 1'b0;
    logic [CREG_W-1:0] creg_wdata = '0;
    logic [CREG_W-1:0] creg_rdata;
    logic              prev_tmo = 1'b0;
    logic              wd_enable, wd_free_run, wd_fast_clk, wd_reboot_en;
    logic [1:0]        wd_int_type;
    logic [PRE_W-1:0]  wd_preload1, wd_preload2;
    logic              wd_reload, wd_flag_clr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdog_regfront #(.DATA_W(DATA_W), .PRE_W(PRE_W), .CREG_W(CREG_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .creg_we(creg_we), .creg_sel(creg_sel), .creg_wdata(creg_wdata), .creg_rdata(creg_rdata),
        .prev_tmo(prev_tmo),
        .wd_enable(wd_enable), .wd_free_run(wd_free_run), .wd_fast_clk(wd_fast_clk),
        .wd_int_type(wd_int_type), .wd_reboot_en(wd_reboot_en),
        .wd_preload1(wd_preload1), .wd_preload2(wd_preload2),
        .wd_reload(wd_reload), .wd_flag_clr(wd_flag_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Window write: driven on a falling edge, captured on the next rising edge,
    // returns at the falling edge where the results are visible.
    task automatic mwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic cwr(input logic s, input logic [7:0] d);
        @(negedge clk);
        creg_we = 1'b1; creg_sel = s; creg_wdata = d;
        @(negedge clk);
        creg_we = 1'b0;
    endtask

    task automatic unlock();
        mwr(4'hC, 32'h80);
        mwr(4'hC, 32'h86);
    endtask

    task automatic creg_read(input logic s, output logic [7:0] v);
        creg_sel = s; #1; v = creg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 preload1", 32'(wd_preload1), 32'hFFFFF);
        check("R1 preload2", 32'(wd_preload2), 32'hFFFFF);
        check("R1 enable/free/lock", {29'd0, wd_enable, wd_free_run, dut.lock_q}, 32'd0);
        check("R1 reboot/fast/int", {28'd0, wd_reboot_en, wd_fast_clk, wd_int_type}, 32'h8);
        creg_read(1'b0, v); check("R1 cfg readback", 32'(v), 32'h0);
        creg_read(1'b1, v); check("R1 lock readback", 32'(v), 32'h0);
        check("R1 pulses idle", {30'd0, wd_reload, wd_flag_clr}, 32'd0);
    endtask

    task automatic t_no_unlock();
        mwr(4'h0, 32'h00012345);
        check("R2 no key, preload1 kept", 32'(wd_preload1), 32'hFFFFF);
        mwr(4'hC, 32'h86);
        mwr(4'h4, 32'h00000111);
        check("R2 arm without open, preload2 kept", 32'(wd_preload2), 32'hFFFFF);
        mwr(4'hC, 32'h80);
        mwr(4'h0, 32'h00000222);
        check("R2 open only, preload1 kept", 32'(wd_preload1), 32'hFFFFF);
        // Re-opening from step 1 then arming still works.
        mwr(4'hC, 32'h80);
        mwr(4'hC, 32'h80);
        mwr(4'hC, 32'h86);
        mwr(4'h0, 32'h00000333);
        check("R2 reopen then arm, preload1 loaded", 32'(wd_preload1), 32'h333);
    endtask

    task automatic t_preload();
        unlock();
        mwr(4'h0, 32'hFFF12345);
        check("R4 preload1 masked", 32'(wd_preload1), 32'h12345);
        unlock();
        mwr(4'h4, 32'h123ABCDE);
        check("R4 preload2 masked", 32'(wd_preload2), 32'hABCDE);
        mwr(4'h0, 32'h00000777);
        check("R3 second write not granted", 32'(wd_preload1), 32'h12345);
    endtask

    task automatic t_undecoded();
        unlock();
        mwr(4'h8, 32'h00000055);
        mwr(4'h0, 32'h00000001);
        check("R3 undecoded write used the grant", 32'(wd_preload1), 32'h12345);
    endtask

    task automatic t_reload();
        unlock();
        mwr(4'hC, 32'h00000100);
        check("R8 reload pulse high", {31'd0, wd_reload}, 32'd1);
        check("R9 no clear on reload", {31'd0, wd_flag_clr}, 32'd0);
        @(negedge clk);
        check("R8 reload pulse one cycle", {31'd0, wd_reload}, 32'd0);
        mwr(4'hC, 32'h00000100);
        check("R8 no reload without key", {31'd0, wd_reload}, 32'd0);
    endtask

    task automatic t_flag();
        unlock();
        mwr(4'hC, 32'h00000200);
        check("R9 clear via bit 9", {30'd0, wd_flag_clr, wd_reload}, 32'd2);
        @(negedge clk);
        check("R9 clear one cycle", {31'd0, wd_flag_clr}, 32'd0);
        unlock();
        mwr(4'hC, 32'h00001000);
        check("R9 clear via bit 12", {31'd0, wd_flag_clr}, 32'd1);
    endtask

    task automatic t_readback();
        prev_tmo = 1'b1; mem_addr = 4'hC; #1;
        check("R10 flag set reads 0x1200", mem_rdata, 32'h1200);
        mem_addr = 4'h0; #1;
        check("R10 other offset reads 0", mem_rdata, 32'h0);
        prev_tmo = 1'b0; mem_addr = 4'hC; #1;
        check("R10 flag clear reads 0", mem_rdata, 32'h0);
    endtask

    task automatic t_config();
        logic [7:0] v;
        cwr(1'b0, 8'h26);
        check("R7 cfg 0x26 fields", {28'd0, wd_reboot_en, wd_fast_clk, wd_int_type}, 32'h6);
        creg_read(1'b0, v); check("R7 cfg 0x26 readback", 32'(v), 32'h26);
        cwr(1'b0, 8'h03);
        check("R7 cfg 0x03 fields", {28'd0, wd_reboot_en, wd_fast_clk, wd_int_type}, 32'hB);
        creg_read(1'b0, v); check("R7 cfg 0x03 readback", 32'(v), 32'h03);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        cwr(1'b1, 8'h06);
        check("R5 enable+free, unlocked", {30'd0, wd_enable, wd_free_run}, 32'd3);
        creg_read(1'b1, v); check("R5 lock byte readback", 32'(v), 32'h06);
        cwr(1'b1, 8'h03);
        creg_read(1'b1, v); check("R5 lock set, free off", 32'(v), 32'h03);
        cwr(1'b1, 8'h04);
        creg_read(1'b1, v); check("R6 write ignored while locked", 32'(v), 32'h03);
        check("R6 enable held", {30'd0, wd_enable, wd_free_run}, 32'd2);
        do_reset();
        creg_read(1'b1, v); check("R6 reset clears lock", 32'(v), 32'h00);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        do_reset();
        t_reset();
        t_no_unlock();
        t_preload();
        t_undecoded();
        t_reload();
        t_flag();
        t_readback();
        t_config();
        t_lock();
        summary();
    end

endmodule